// File: doc/BRIEF.md
# Functional Broadside Test Generator

This block produces on-chip functional broadside tests for a small sequential circuit under test that has four primary inputs and three state flip-flops. After a start request it first asks the circuit under test to enter its reset state, which is known to be reachable. It then drives the circuit's primary inputs in functional mode for a fixed number of time units. The input bits come from a linear-feedback shift register, passed through a handful of fixed gates. Because the circuit is only ever clocked functionally from a reachable state, every state it passes through is reachable.

The gates between the register and the inputs mix or bias pairs of register bits. This keeps the random stream from pulling the circuit back into the same few states again and again. A single AND gate over two other register bits marks the time units whose present circuit state becomes the initial state of a two-cycle test. The launch cycle is that time unit and the capture cycle is the next one. Scan shifting is never used for these tests, so scan enable stays low.

Several seeds can be loaded one after another between runs. Each seed gives a different input sequence and a different subset of selected tests. When no seed is loaded, a run continues the register from where the previous run left it.

Top module: `fbt_gen`

## Requirements
- R1: After reset the register holds the preset value 12'hA5B, the block is idle, and pi_vec, test_sel, cut_init and done are all 0.
- R2: While idle, a seed_load pulse copies seed_in into the register. A seed of all zeros is replaced by the preset value.
- R3: A start pulse accepted while idle gives exactly one cycle with cut_init=1. The next cycle is run time unit 0, and the run lasts SEQ_LEN cycles.
- R4: In every run cycle the register advances to {l[W-2:0], ^(l & TAPS)}. The default TAPS is 12'h829, which selects bits 11, 5, 3 and 0. Outside a run the register only changes through a seed load.
- R5: During a run, pi_vec[0]=l[0]^l[6], pi_vec[1]=l[1]|l[8], pi_vec[2]=l[2]&l[9] and pi_vec[3]=~(l[3]^l[10]), where l is the register's current value. Outside a run pi_vec is 0.
- R6: During run unit u, test_sel equals l[4]&l[11] and lasts that single (launch) cycle. It is forced to 0 at the final unit SEQ_LEN-1, because no capture cycle follows that unit.
- R7: scan_en is 0 in every cycle.
- R8: done rises in the cycle after the final run unit and stays high while idle. It clears when a start is accepted.
- R9: start and seed_load have no effect during the cut_init cycle or a run.
- R10: With no seed loaded between runs, the next run continues from the register value the previous run left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (used only while idle) |
| seed_load | input | 1 | Load seed_in into the register (used only while idle) |
| seed_in | input | LFSR_W | Seed value |
| cut_init | output | 1 | One-cycle request to put the circuit under test in its reset state |
| pi_vec | output | 4 | Primary-input vector for the circuit under test |
| scan_en | output | 1 | Scan enable, held low |
| test_sel | output | 1 | Launch-cycle strobe of a selected test |
| done | output | 1 | Sequence finished |

## Verification
The bench builds the block with the 12-bit register, the default tap mask and preset, and SEQ_LEN set to 20. With a short sequence, ten complete runs fit in a brief simulation. That covers the carry-over of the register between runs, the all-zero seed substitution, several random seeds, and the forced-low select at the last unit of every run. Random start and seed_load pulses are driven inside each run, and any effect they had would show up as a deviation in the compared input and select streams.

// File: rtl/fbt_gen.sv
module fbt_gen #(
  parameter int LFSR_W = 12,
  parameter int SEQ_LEN = 64,
  parameter logic [LFSR_W-1:0] TAPS = 12'h829,
  parameter logic [LFSR_W-1:0] PRESET = 12'hA5B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              seed_load,
  input  logic [LFSR_W-1:0] seed_in,
  output logic              cut_init,
  output logic [3:0]        pi_vec,
  output logic              scan_en,
  output logic              test_sel,
  output logic              done
);
  localparam int CW = (SEQ_LEN > 2) ? $clog2(SEQ_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(SEQ_LEN - 1);

  typedef enum logic [1:0] {S_IDLE, S_INIT, S_RUN} st_t;

  st_t              st;
  logic [LFSR_W-1:0] lfsr;
  logic [CW-1:0]     cnt;
  logic              run, fb, sel_gate;

  assign run      = (st == S_RUN);
  assign fb       = ^(lfsr & TAPS);
  assign sel_gate = lfsr[4] & lfsr[11];

  assign cut_init = (st == S_INIT);
  assign scan_en  = 1'b0;
  assign test_sel = run && sel_gate && (cnt != LAST);
  assign pi_vec   = run ? {~(lfsr[3] ^ lfsr[10]), lfsr[2] & lfsr[9],
                           lfsr[1] | lfsr[8], lfsr[0] ^ lfsr[6]} : 4'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      lfsr <= PRESET;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (seed_load) lfsr <= (seed_in == '0) ? PRESET : seed_in;
          if (start) begin
            st   <= S_INIT;
            done <= 1'b0;
          end
        end
        S_INIT: begin
          st  <= S_RUN;
          cnt <= '0;
        end
        S_RUN: begin
          lfsr <= {lfsr[LFSR_W-2:0], fb};
          cnt  <= cnt + 1'b1;
          if (cnt == LAST) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r4_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);
  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_RUN && !(st == S_IDLE && seed_load)) |=> $stable(lfsr));
  a_r3_init_then_run: assert property (@(posedge clk) disable iff (!rst_n)
    cut_init |=> (run && cnt == '0));
  a_r6_no_last_select: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == LAST) |-> !test_sel);
  a_r6_sel_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    test_sel |-> !done);
  a_r8_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(run));
  a_r5_pi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> pi_vec == 4'b0);
  a_r9_run_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != LAST) |=> run);
endmodule

// File: tb/fbt_gen_test.sv
module fbt_gen_test;
  localparam int W = 12;
  localparam int LEN = 20;
  localparam logic [W-1:0] TAPS = 12'h829;
  localparam logic [W-1:0] PRE = 12'hA5B;

  logic clk = 0, rst_n = 0, start = 0, seed_load = 0;
  logic [W-1:0] seed_in = '0;
  logic cut_init, scan_en, test_sel, done;
  logic [3:0] pi_vec;
  int checks = 0, errors = 0;
  logic [W-1:0] m_l;

  fbt_gen #(.LFSR_W(W), .SEQ_LEN(LEN), .TAPS(TAPS), .PRESET(PRE)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .seed_load(seed_load),
    .seed_in(seed_in), .cut_init(cut_init), .pi_vec(pi_vec),
    .scan_en(scan_en), .test_sel(test_sel), .done(done));

  always #2.5 clk = ~clk;

  function automatic logic [3:0] shape(logic [W-1:0] l);
    return {~(l[3] ^ l[10]), l[2] & l[9], l[1] | l[8], l[0] ^ l[6]};
  endfunction
  function automatic logic [W-1:0] nxt(logic [W-1:0] l);
    return {l[W-2:0], ^(l & TAPS)};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_seq(bit ld, logic [W-1:0] sd);
    seed_load = ld; seed_in = sd;
    @(negedge clk);
    seed_load = 0;
    if (ld) m_l = (sd == '0) ? PRE : sd;
    chk("R9 idle pi", {12'b0, pi_vec}, 16'h0);
    start = 1;
    @(negedge clk);
    start = 0;
    chk("R3 cut_init", {15'b0, cut_init}, 16'h1);
    chk("R8 done cleared", {15'b0, done}, 16'h0);
    @(negedge clk);
    for (int u = 0; u < LEN; u++) begin
      chk("R5 pi_vec", {12'b0, pi_vec}, {12'b0, shape(m_l)});
      chk("R6 test_sel", {15'b0, test_sel},
          {15'b0, (m_l[4] & m_l[11]) && (u != LEN - 1)});
      chk("R7 scan_en", {15'b0, scan_en}, 16'h0);
      chk("R3 no init in run", {14'b0, cut_init, done}, 16'h0);
      start = 1'($urandom_range(0, 1));
      seed_load = 1'($urandom_range(0, 1));
      seed_in = W'($urandom);
      @(negedge clk);
      m_l = nxt(m_l);
    end
    start = 0; seed_load = 0;
    chk("R8 done set", {15'b0, done}, 16'h1);
    chk("R5 pi idle", {12'b0, pi_vec}, 16'h0);
    @(negedge clk);
    chk("R8 done held", {14'b0, done, test_sel}, 16'h2);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_l = PRE;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset outputs", {11'b0, pi_vec, test_sel, cut_init, done, scan_en}, 16'h0);
    run_seq(0, '0);                 // R1 preset sequence, R10 start point
    run_seq(1, '0);                 // R2 zero seed -> preset
    run_seq(0, '0);                 // R10 carry-over
    for (int k = 0; k < 6; k++) run_seq(1, W'($urandom));  // R2 R4
    run_seq(1, 12'hFFF);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule